// File: doc/BRIEF.md
# Floppy Drive Power and Select Sequencer

This block sequences one floppy drive behind a USB bridge. It keeps the drive powered while the device is awake and releases power on suspend. It asserts the drive select, and starts the motor only once the drive has answered with its ready line while selected. It then opens the write gate only for unprotected media. Firmware gives it level requests (select, spin, write, fast spindle, head side) and a ready timeout limit. The block returns the six active-low drive lines and a timeout flag.

All drive lines are registered. Each one changes on the clock edge after the inputs that cause it are sampled, and every line rests high when nothing is requested. On suspend the block drops select, motor and write gate one cycle before it releases power. On wake it waits for power before it selects the drive again.

Top module: `fdd_pwr_seq`

## Requirements
- R1: `pwr_n_o` goes low two clock edges after `suspend_i` is sampled low, and high two edges after `suspend_i` is sampled high.
- R2: `sel_n_o` goes low on the edge after `sel_req_i` is sampled high, but only once `pwr_n_o` is already low; before that, select stays high.
- R3: `mtr_n_o` is low only while select is low, `spin_req_i` is high and `drv_rdy_n_i` has been sampled low on an edge where select was already low; the motor never goes low on the same edge as select.
- R4: With `drv_rdy_n_i` held low, the motor goes low exactly one edge after select goes low.
- R5: `wgate_n_o` goes low on the same edge as the motor when `wr_req_i` is high and `wr_prot_n_i` is high.
- R6: While `wr_prot_n_i` is low (protected), write requests are ignored and `wgate_n_o` stays high.
- R7: `dens_n_o` is low (fast 360 RPM spindle) while selected with `fast_spin_i` high; otherwise it is high (300 RPM).
- R8: `head_n_o` is low (side 1) while selected with `side_i` high; high means side 0, which is also the idle level.
- R9: When `sel_req_i` is sampled low, select, motor and write gate all go high on the next edge, and `rdy_err_o` clears.
- R10: If the drive is still not ready, `rdy_err_o` rises `rdy_limit_i` edges after the edge that asserted select. It stays set while select is held, even after ready arrives. A limit of 0 disables the timeout.
- R11: Suspend drives select, motor and write gate high one edge before `pwr_n_o` rises. Select requests are ignored while suspended.
- R12: Under reset, all six drive lines are high and `rdy_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend_i | input | 1 | Device in suspend |
| drv_rdy_n_i | input | 1 | Drive ready, active low |
| wr_prot_n_i | input | 1 | Media write protected when low |
| sel_req_i | input | 1 | Firmware select request |
| spin_req_i | input | 1 | Firmware motor request |
| wr_req_i | input | 1 | Firmware write request |
| fast_spin_i | input | 1 | Request 360 RPM spindle |
| side_i | input | 1 | Head side request (1 = side 1) |
| rdy_limit_i | input | CNT_W | Ready timeout in cycles, 0 disables |
| pwr_n_o | output | 1 | Drive power enable, active low |
| sel_n_o | output | 1 | Drive select, active low |
| mtr_n_o | output | 1 | Motor on, active low |
| wgate_n_o | output | 1 | Write gate, active low |
| dens_n_o | output | 1 | Spindle speed select, low = 360 RPM |
| head_n_o | output | 1 | Head select, high = side 0 |
| rdy_err_o | output | 1 | Ready timeout flag |

## Verification
The bench drives select requests before power is up and checks that select waits for power. A design that gated only on the suspend input would select an unpowered drive. It holds ready high past the timeout and then releases it, checking that the motor waits, the flag rises on the exact edge, and a limit of zero never fires. Write requests on protected media must leave the gate closed: an ungated design would open it together with the motor. Suspend is entered while armed, and the bench checks that power lags the other lines by one edge. Releasing power in the same cycle would leave select and motor driven into a dead drive.

// File: rtl/fdd_seq_pkg.sv
package fdd_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ARMED = 2'd2
    } seq_state_e;

    // Firmware requests, sampled every cycle
    typedef struct packed {
        logic sel;
        logic spin;
        logic wr;
        logic fast;
        logic side;
    } fdd_req_t;

    // Drive lines in active-high intent form
    typedef struct packed {
        logic sel;
        logic mtr;
        logic wgate;
        logic dens;
        logic head;
    } fdd_lines_t;

    localparam int LINE_W = $bits(fdd_lines_t);

    function automatic fdd_lines_t lines_for(seq_state_e nxt, fdd_req_t rq, logic prot_n);
        fdd_lines_t l;
        l.sel   = (nxt != ST_IDLE);
        l.mtr   = (nxt == ST_ARMED) && rq.spin;
        l.wgate = l.mtr && rq.wr && prot_n;
        l.dens  = l.sel && rq.fast;
        l.head  = l.sel && rq.side;
        return l;
    endfunction

endpackage

// File: rtl/fdd_seq_fsm.sv
module fdd_seq_fsm
    import fdd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       suspend,
    input  logic       pwr_on,
    input  logic       rdy_n,
    input  fdd_req_t   req,
    output seq_state_e state_q,
    output seq_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req.sel && !suspend && pwr_on) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!req.sel || suspend) state_d = ST_IDLE;
                else if (!rdy_n)         state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!req.sel || suspend) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/fdd_rdy_timer.sv
module fdd_rdy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             waiting,
    input  logic             rdy_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             hit;

    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    // never true for a zero limit, since cnt_inc is at least one
    assign hit     = waiting && rdy_n && (cnt_inc == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !waiting)      cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_inc[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) err <= 1'b0;
        else if (hit)     err <= 1'b1;
    end
endmodule

// File: rtl/fdd_pin_reg.sv
module fdd_pin_reg
    import fdd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       suspend,
    input  seq_state_e state_d,
    input  fdd_req_t   req,
    input  logic       prot_n,
    output logic       pwr_on,
    output logic       pwr_n,
    output fdd_lines_t lines_n
);
    logic       susp_q;
    fdd_lines_t drive;

    assign drive = lines_for(state_d, req, prot_n);

    // Power lags suspend by two edges so the other lines drop first
    always_ff @(posedge clk) begin
        if (rst) begin
            susp_q <= 1'b1;
            pwr_n  <= 1'b1;
        end else begin
            susp_q <= suspend;
            pwr_n  <= susp_q;
        end
    end

    generate
        for (genvar i = 0; i < LINE_W; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) lines_n[i] <= 1'b1;
                else     lines_n[i] <= ~drive[i];
            end
        end
    endgenerate

    assign pwr_on = ~pwr_n;
endmodule

// File: rtl/fdd_pwr_seq.sv
module fdd_pwr_seq
    import fdd_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspend_i,
    input  logic             drv_rdy_n_i,
    input  logic             wr_prot_n_i,
    input  logic             sel_req_i,
    input  logic             spin_req_i,
    input  logic             wr_req_i,
    input  logic             fast_spin_i,
    input  logic             side_i,
    input  logic [CNT_W-1:0] rdy_limit_i,
    output logic             pwr_n_o,
    output logic             sel_n_o,
    output logic             mtr_n_o,
    output logic             wgate_n_o,
    output logic             dens_n_o,
    output logic             head_n_o,
    output logic             rdy_err_o
);
    fdd_req_t   req;
    seq_state_e st_q, st_d;
    logic       pwr_on;
    fdd_lines_t lines_n;

    assign req = '{sel: sel_req_i, spin: spin_req_i, wr: wr_req_i,
                   fast: fast_spin_i, side: side_i};

    fdd_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .suspend (suspend_i),
        .pwr_on  (pwr_on),
        .rdy_n   (drv_rdy_n_i),
        .req     (req),
        .state_q (st_q),
        .state_d (st_d)
    );

    fdd_rdy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .waiting (st_q == ST_WAIT),
        .rdy_n   (drv_rdy_n_i),
        .clear   (st_d == ST_IDLE),
        .limit   (rdy_limit_i),
        .err     (rdy_err_o)
    );

    fdd_pin_reg u_pins (
        .clk     (clk),
        .rst     (rst),
        .suspend (suspend_i),
        .state_d (st_d),
        .req     (req),
        .prot_n  (wr_prot_n_i),
        .pwr_on  (pwr_on),
        .pwr_n   (pwr_n_o),
        .lines_n (lines_n)
    );

    assign sel_n_o   = lines_n.sel;
    assign mtr_n_o   = lines_n.mtr;
    assign wgate_n_o = lines_n.wgate;
    assign dens_n_o  = lines_n.dens;
    assign head_n_o  = lines_n.head;
endmodule

// File: rtl/fdd_seq_chk.sv
module fdd_seq_chk (
    input logic clk,
    input logic rst,
    input logic suspend_i,
    input logic sel_req_i,
    input logic wr_prot_n_i,
    input logic pwr_n_o,
    input logic sel_n_o,
    input logic mtr_n_o,
    input logic wgate_n_o,
    input logic rdy_err_o
);
    // R1
    pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        suspend_i |=> ##1 pwr_n_o);

    // R11
    sel_needs_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_n_o |-> sel_n_o);

    // R3
    mtr_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !mtr_n_o |-> !sel_n_o);

    // R3
    mtr_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mtr_n_o) |-> $past(!sel_n_o));

    // R5
    wg_needs_mtr_chk: assert property (@(posedge clk) disable iff (rst)
        !wgate_n_o |-> !mtr_n_o);

    // R6
    wg_prot_chk: assert property (@(posedge clk) disable iff (rst)
        !wgate_n_o |-> $past(wr_prot_n_i));

    // R9
    sel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_req_i |=> (sel_n_o && mtr_n_o && wgate_n_o && !rdy_err_o));
endmodule

bind fdd_pwr_seq fdd_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .suspend_i   (suspend_i),
    .sel_req_i   (sel_req_i),
    .wr_prot_n_i (wr_prot_n_i),
    .pwr_n_o     (pwr_n_o),
    .sel_n_o     (sel_n_o),
    .mtr_n_o     (mtr_n_o),
    .wgate_n_o   (wgate_n_o),
    .rdy_err_o   (rdy_err_o)
);

// File: tb/sim_fdd_pwr_seq.sv
module sim_fdd_pwr_seq;
    localparam int CW = 16;
    localparam logic [6:0] B_PWR = 7'b1000000;
    localparam logic [6:0] B_SEL = 7'b0100000;
    localparam logic [6:0] B_MTR = 7'b0010000;
    localparam logic [6:0] B_WG  = 7'b0001000;
    localparam logic [6:0] B_DEN = 7'b0000100;
    localparam logic [6:0] B_HD  = 7'b0000010;
    localparam logic [6:0] B_ERR = 7'b0000001;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, suspend, rdy_n, prot_n, sel, spin, wr, fast, side;
    logic [CW-1:0] limit;
    logic pwr_n_o, sel_n_o, mtr_n_o, wgate_n_o, dens_n_o, head_n_o, rdy_err_o;

    fdd_pwr_seq #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .suspend_i(suspend), .drv_rdy_n_i(rdy_n),
        .wr_prot_n_i(prot_n), .sel_req_i(sel), .spin_req_i(spin), .wr_req_i(wr),
        .fast_spin_i(fast), .side_i(side), .rdy_limit_i(limit),
        .pwr_n_o(pwr_n_o), .sel_n_o(sel_n_o), .mtr_n_o(mtr_n_o),
        .wgate_n_o(wgate_n_o), .dens_n_o(dens_n_o), .head_n_o(head_n_o),
        .rdy_err_o(rdy_err_o)
    );

    typedef struct {
        int         when;
        string      tag;
        logic [6:0] mask;
        logic [6:0] val;
    } exp_t;

    exp_t q[$];
    int   cyc = 0, n_chk = 0, n_fail = 0;
    bit   done = 0;

    wire [6:0] obs = {pwr_n_o, sel_n_o, mtr_n_o, wgate_n_o, dens_n_o, head_n_o, rdy_err_o};

    // Monitor: compare every queued item due in this cycle
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < q.size(); ) begin
            if (q[i].when == cyc) begin
                n_chk = n_chk + 1;
                if ((obs & q[i].mask) !== q[i].val) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s cycle %0d: got %b expected %b (mask %b)",
                             q[i].tag, cyc, obs & q[i].mask, q[i].val, q[i].mask);
                end
                q.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_at(int d, string tag, logic [6:0] m, logic [6:0] v);
        exp_t e;
        e.when = cyc + d;
        e.tag  = tag;
        e.mask = m;
        e.val  = v & m;
        q.push_back(e);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; suspend = 0; rdy_n = 1; prot_n = 1; sel = 0; spin = 0;
        wr = 0; fast = 0; side = 0; limit = 16'd5;
        repeat (3) tick();
        expect_at(1, "R12", 7'h7F, 7'b1111110);
        tick();

        // Power-up, select waits for power, motor waits for ready, timeout
        rst = 0; sel = 1; spin = 1;
        expect_at(1, "R1", B_PWR, B_PWR);
        expect_at(2, "R1", B_PWR, 7'b0);
        expect_at(2, "R2", B_SEL, B_SEL);
        expect_at(3, "R2", B_SEL, 7'b0);
        expect_at(3, "R3", B_MTR, B_MTR);
        expect_at(7, "R10", B_ERR, 7'b0);
        expect_at(8, "R10", B_ERR, B_ERR);
        expect_at(8, "R3", B_MTR, B_MTR);
        repeat (8) tick();
        rdy_n = 0;
        expect_at(1, "R3", B_MTR | B_SEL | B_ERR, B_ERR);
        tick();

        // Protected media blocks the write gate
        prot_n = 0; wr = 1;
        expect_at(1, "R6", B_WG, B_WG);
        expect_at(2, "R6", B_WG, B_WG);
        tick(); tick();
        prot_n = 1;
        expect_at(1, "R5", B_WG | B_MTR, 7'b0);
        tick();

        // Speed and side
        fast = 1; side = 1;
        expect_at(1, "R7", B_DEN, 7'b0);
        expect_at(1, "R8", B_HD, 7'b0);
        tick();

        // Drop select: everything idles together, flag clears
        sel = 0;
        expect_at(1, "R9", 7'h7E | B_ERR, 7'b0111110);
        tick();

        // Ready tied low: motor one edge after select
        sel = 1;
        expect_at(1, "R4", B_SEL | B_MTR | B_DEN, B_MTR);
        expect_at(2, "R4", B_SEL | B_MTR | B_WG, 7'b0);
        repeat (3) tick();

        // Suspend while armed
        suspend = 1;
        expect_at(1, "R11", B_PWR | B_SEL | B_MTR | B_WG, B_SEL | B_MTR | B_WG);
        expect_at(2, "R1", B_PWR, B_PWR);
        expect_at(3, "R11", B_SEL | B_HD | B_DEN, B_SEL | B_HD | B_DEN);
        repeat (4) tick();
        suspend = 0;
        expect_at(1, "R1", B_PWR, B_PWR);
        expect_at(2, "R1", B_PWR, 7'b0);
        expect_at(2, "R2", B_SEL, B_SEL);
        expect_at(3, "R2", B_SEL, 7'b0);
        expect_at(4, "R4", B_MTR, 7'b0);
        repeat (5) tick();

        // Zero limit never times out
        sel = 0; rdy_n = 1; limit = 16'd0;
        tick();
        sel = 1;
        expect_at(1, "R2", B_SEL, 7'b0);
        expect_at(20, "R10", B_ERR | B_MTR, B_MTR);
        repeat (20) tick();

        // Short limit
        sel = 0; limit = 16'd2;
        tick();
        sel = 1;
        expect_at(1, "R2", B_SEL, 7'b0);
        expect_at(2, "R10", B_ERR, 7'b0);
        expect_at(3, "R10", B_ERR, B_ERR);
        repeat (4) tick();
        sel = 0;
        expect_at(1, "R9", B_ERR | B_SEL, B_SEL);
        repeat (3) tick();

        done = 1;
        if (q.size() != 0) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule